// File: doc/BRIEF.md
# Floating-Point Operate Decoder and Register Validator

This block sits at the front of a floating-point pipeline. It takes a 32-bit instruction word and classifies it as one of three things: an arithmetic/conversion operate (group 1), a compare operate (group 2), or no floating-point operate at all. For a recognised operate it looks up the 9-bit operation code. From that it reports the precision of each operand slot: first source, second source and destination. A size of none means the slot is unused. It also reports whether the second source or the destination carries a raw 32-bit integer instead of an IEEE value.

Each used operand's register number is checked against its precision. A compare must also name condition-code set zero as its destination. A fault in any slot raises an invalid-register flag together with its trap-type code. An operation code the block does not recognise within a valid group raises an unimplemented flag instead.

Decoding is combinational. A capture stage, selected by parameter and enabled by an input valid strobe, registers the result. Executing the operation and reading the register file belong to other blocks.

Top module: `fp_op_decoder`

## Requirements
- R1: A word is group 1 when `insn & 0xC1F80000 == 0x81A00000`. It is group 2 when the same masked value is `0x81A80000`. Any other word reports group 0 (group codes: 0 none, 1 arithmetic, 2 compare), all sizes none, and no unimplemented, invalid-register or compare flag.
- R2: The operation code is taken from bits 13:5. Register indices are reported as: first source from bits 18:14, second source from bits 4:0, destination from bits 29:25.
- R3: Size codes are 0 none, 1 single, 2 double, 3 quad. Group-1 codes 0x041–0x04F (add, subtract, multiply, divide; the low two bits give the precision, low bits 00 excluded) use that precision on all three slots. Square root 0x029/0x02A/0x02B has no first source and the same precision on the other two slots. 0x069 takes two singles to a double; 0x06E takes two doubles to a quad.
- R4: The integer-to-float codes 0x0C4/0x0C8/0x0CC read a raw-integer single and write single/double/quad. The float-to-integer codes 0x0D1/0x0D2/0x0D3 read single/double/quad and write a raw-integer single. The precision changes are 0x0C6 (double→single), 0x0C7 (quad→single), 0x0C9 (single→double), 0x0CB (quad→double), 0x0CD (single→quad) and 0x0CE (double→quad). Move 0x001, negate 0x005 and absolute 0x009 use raw singles in both used slots. None of these codes has a first source.
- R5: A double operand whose register bit 0 is 1 is misaligned. So is a quad operand whose register bits 1:0 are nonzero. A slot of size none is never checked.
- R6: Group-2 codes 0x051/0x052/0x053 (quiet) and 0x055/0x056/0x057 (signalling) compare two operands whose precision is given by the low two code bits. They report destination size none and set the compare flag. A nonzero destination field is an invalid-register fault.
- R7: Any fault from R5 or R6 sets the invalid-register flag and trap code 6 (3 bits). Without a fault the trap code is 0.
- R8: A group-1 or group-2 word whose code is not listed for its group sets the unimplemented flag. It reports all sizes none, clears raw and compare flags, and raises no invalid-register fault.
- R9: The result appears on the outputs after the first rising clock edge on which the input valid strobe is high, and output valid follows input valid one cycle later. While input valid is low the decoded outputs hold. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture strobe for `insn` |
| insn | input | 32 | Instruction word |
| out_valid | output | 1 | A decoded result was captured on the last edge |
| out_group | output | 2 | 0 none, 1 arithmetic/convert, 2 compare |
| out_rs1_idx | output | 5 | First-source register number |
| out_rs2_idx | output | 5 | Second-source register number |
| out_rd_idx | output | 5 | Destination register number |
| out_rs1_sz | output | 2 | First-source size code |
| out_rs2_sz | output | 2 | Second-source size code |
| out_rd_sz | output | 2 | Destination size code |
| out_rs2_int | output | 1 | Second source is a raw integer |
| out_rd_int | output | 1 | Destination is a raw integer |
| out_cmp | output | 1 | Destination is the condition code |
| out_unimpl | output | 1 | Unrecognised operation code in a valid group |
| out_badreg | output | 1 | Invalid-register fault |
| out_trap | output | 3 | Trap-type code (6 on fault) |

## Verification
The bench aims at register numbers that are legal at one precision and illegal at another. Examples are an odd register in a single slot next to an odd register in a double slot, and register 2 or 6 in a quad slot. A design that checked alignment from the wrong slot's size, or checked unused slots, would flag clean words or miss faults. Compares are driven with destination 0 and nonzero, and with odd single registers, because a design that applied destination alignment rules to the condition code would misreport them. Unlisted codes in each group, words that miss the group mask by a single bit, and idle cycles with a changing bus target leaked faults on unimplemented codes, loose mask matching and outputs that fail to hold.

// File: rtl/fpd_pkg.sv
`timescale 1ns/1ps
package fpd_pkg;
   localparam int INSN_W = 32;
   localparam int IDX_W  = 5;
   localparam int OPC_W  = 9;
   localparam int TRAP_W = 3;

   localparam logic [INSN_W-1:0] FPOP_MASK   = 32'hC1F8_0000;
   localparam logic [INSN_W-1:0] FPOP1_MATCH = 32'h81A0_0000;
   localparam logic [INSN_W-1:0] FPOP2_MATCH = 32'h81A8_0000;

   typedef enum logic [1:0] {SZ_NONE = 2'd0, SZ_SGL = 2'd1, SZ_DBL = 2'd2, SZ_QUAD = 2'd3} opsz_e;
   typedef enum logic [1:0] {GRP_NONE = 2'd0, GRP_ARITH = 2'd1, GRP_CMP = 2'd2} grp_e;

   typedef struct packed {
      logic  known;
      opsz_e a_sz;
      opsz_e b_sz;
      opsz_e d_sz;
      logic  b_raw;
      logic  d_raw;
      logic  cmp;
   } opdesc_t;

   typedef struct packed {
      grp_e              grp;
      logic [IDX_W-1:0]  a_idx;
      logic [IDX_W-1:0]  b_idx;
      logic [IDX_W-1:0]  d_idx;
      opsz_e             a_sz;
      opsz_e             b_sz;
      opsz_e             d_sz;
      logic              b_raw;
      logic              d_raw;
      logic              cmp;
      logic              unimpl;
      logic              badreg;
      logic [TRAP_W-1:0] trap;
   } dec_res_t;

   function automatic opdesc_t desc(input opsz_e a, input opsz_e b, input opsz_e d,
                                    input logic braw, input logic draw, input logic c);
      opdesc_t r;
      r.known = 1'b1;
      r.a_sz  = a;
      r.b_sz  = b;
      r.d_sz  = d;
      r.b_raw = braw;
      r.d_raw = draw;
      r.cmp   = c;
      return r;
   endfunction
endpackage

// File: rtl/fpd_opmap.sv
`timescale 1ns/1ps
module fpd_opmap
   import fpd_pkg::*;
#(
   parameter int OPC_BITS = 9
) (
   input  grp_e                grp,
   input  logic [OPC_BITS-1:0] opc,
   output opdesc_t             d
);
   if (OPC_BITS != 9) begin : g_bad_opc
      $error("fpd_opmap: operation field must be 9 bits");
   end

   always_comb begin
      d = '0;
      if (grp == GRP_ARITH) begin
         unique case (opc)
            9'h041, 9'h045, 9'h049, 9'h04D: d = desc(SZ_SGL,  SZ_SGL,  SZ_SGL,  1'b0, 1'b0, 1'b0);
            9'h042, 9'h046, 9'h04A, 9'h04E: d = desc(SZ_DBL,  SZ_DBL,  SZ_DBL,  1'b0, 1'b0, 1'b0);
            9'h043, 9'h047, 9'h04B, 9'h04F: d = desc(SZ_QUAD, SZ_QUAD, SZ_QUAD, 1'b0, 1'b0, 1'b0);
            9'h029: d = desc(SZ_NONE, SZ_SGL,  SZ_SGL,  1'b0, 1'b0, 1'b0);
            9'h02A: d = desc(SZ_NONE, SZ_DBL,  SZ_DBL,  1'b0, 1'b0, 1'b0);
            9'h02B: d = desc(SZ_NONE, SZ_QUAD, SZ_QUAD, 1'b0, 1'b0, 1'b0);
            9'h069: d = desc(SZ_SGL,  SZ_SGL,  SZ_DBL,  1'b0, 1'b0, 1'b0);
            9'h06E: d = desc(SZ_DBL,  SZ_DBL,  SZ_QUAD, 1'b0, 1'b0, 1'b0);
            9'h0C4: d = desc(SZ_NONE, SZ_SGL,  SZ_SGL,  1'b1, 1'b0, 1'b0);
            9'h0C8: d = desc(SZ_NONE, SZ_SGL,  SZ_DBL,  1'b1, 1'b0, 1'b0);
            9'h0CC: d = desc(SZ_NONE, SZ_SGL,  SZ_QUAD, 1'b1, 1'b0, 1'b0);
            9'h0D1: d = desc(SZ_NONE, SZ_SGL,  SZ_SGL,  1'b0, 1'b1, 1'b0);
            9'h0D2: d = desc(SZ_NONE, SZ_DBL,  SZ_SGL,  1'b0, 1'b1, 1'b0);
            9'h0D3: d = desc(SZ_NONE, SZ_QUAD, SZ_SGL,  1'b0, 1'b1, 1'b0);
            9'h0C6: d = desc(SZ_NONE, SZ_DBL,  SZ_SGL,  1'b0, 1'b0, 1'b0);
            9'h0C7: d = desc(SZ_NONE, SZ_QUAD, SZ_SGL,  1'b0, 1'b0, 1'b0);
            9'h0C9: d = desc(SZ_NONE, SZ_SGL,  SZ_DBL,  1'b0, 1'b0, 1'b0);
            9'h0CB: d = desc(SZ_NONE, SZ_QUAD, SZ_DBL,  1'b0, 1'b0, 1'b0);
            9'h0CD: d = desc(SZ_NONE, SZ_SGL,  SZ_QUAD, 1'b0, 1'b0, 1'b0);
            9'h0CE: d = desc(SZ_NONE, SZ_DBL,  SZ_QUAD, 1'b0, 1'b0, 1'b0);
            9'h001, 9'h005, 9'h009:
                    d = desc(SZ_NONE, SZ_SGL,  SZ_SGL,  1'b1, 1'b1, 1'b0);
            default: d = '0;
         endcase
      end else if (grp == GRP_CMP) begin
         unique case (opc)
            9'h051, 9'h055: d = desc(SZ_SGL,  SZ_SGL,  SZ_NONE, 1'b0, 1'b0, 1'b1);
            9'h052, 9'h056: d = desc(SZ_DBL,  SZ_DBL,  SZ_NONE, 1'b0, 1'b0, 1'b1);
            9'h053, 9'h057: d = desc(SZ_QUAD, SZ_QUAD, SZ_NONE, 1'b0, 1'b0, 1'b1);
            default: d = '0;
         endcase
      end
   end
endmodule

// File: rtl/fpd_align_chk.sv
`timescale 1ns/1ps
module fpd_align_chk
   import fpd_pkg::*;
#(
   parameter int IDX_BITS = 5
) (
   input  logic [IDX_BITS-1:0] idx,
   input  opsz_e               sz,
   input  logic                must_zero,
   output logic                bad
);
   if (IDX_BITS < 2) begin : g_bad_idx
      $error("fpd_align_chk: register number needs at least 2 bits");
   end

   logic dbl_bad, quad_bad, zero_bad;

   always_comb begin
      dbl_bad  = (sz == SZ_DBL)  && idx[0];
      quad_bad = (sz == SZ_QUAD) && (idx[1:0] != 2'b00);
      zero_bad = must_zero && (idx != '0);
      bad      = dbl_bad | quad_bad | zero_bad;
   end
endmodule

// File: rtl/fpd_out_stage.sv
`timescale 1ns/1ps
module fpd_out_stage #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] d,
   output logic         q_valid,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("fpd_out_stage: width must be positive");
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
         end else begin
            q_valid <= in_valid;
            if (in_valid) q <= d;
         end
      end

      p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> q_valid);
      p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !q_valid);
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(q));
   end else begin : g_comb
      assign q_valid = in_valid;
      assign q       = d;
   end
endmodule

// File: rtl/fp_op_decoder.sv
`timescale 1ns/1ps
module fp_op_decoder
   import fpd_pkg::*;
#(
   parameter int REG_IDX_W  = 5,
   parameter int OP_W       = 9,
   parameter int TRAP_BITS  = 3,
   parameter int RS2_LSB    = 0,
   parameter int OPC_LSB    = 5,
   parameter int RS1_LSB    = 14,
   parameter int RD_LSB     = 25,
   parameter int BADREG_TT  = 6,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [31:0]          insn,
   output logic                 out_valid,
   output logic [1:0]           out_group,
   output logic [REG_IDX_W-1:0] out_rs1_idx,
   output logic [REG_IDX_W-1:0] out_rs2_idx,
   output logic [REG_IDX_W-1:0] out_rd_idx,
   output logic [1:0]           out_rs1_sz,
   output logic [1:0]           out_rs2_sz,
   output logic [1:0]           out_rd_sz,
   output logic                 out_rs2_int,
   output logic                 out_rd_int,
   output logic                 out_cmp,
   output logic                 out_unimpl,
   output logic                 out_badreg,
   output logic [TRAP_BITS-1:0] out_trap
);
   localparam int NOPS  = 3;
   localparam int RES_W = $bits(dec_res_t);

   if (REG_IDX_W != IDX_W || OP_W != OPC_W || TRAP_BITS != TRAP_W) begin : g_bad_w
      $error("fp_op_decoder: widths must match fpd_pkg");
   end
   if (RD_LSB + REG_IDX_W > 32 || RS1_LSB + REG_IDX_W > RD_LSB || OPC_LSB + OP_W > RS1_LSB) begin : g_bad_pos
      $error("fp_op_decoder: field positions overlap or overflow");
   end
   if (BADREG_TT >= (1 << TRAP_BITS)) begin : g_bad_tt
      $error("fp_op_decoder: trap code does not fit");
   end

   grp_e              grp_c;
   logic [OP_W-1:0]   opc;
   opdesc_t           dsc;
   dec_res_t          res_c;
   dec_res_t          res_q;
   logic [RES_W-1:0]  res_q_bits;
   logic              fp_c;

   logic [REG_IDX_W-1:0] idx_a [NOPS];
   opsz_e                sz_a  [NOPS];
   logic [NOPS-1:0]      bad_a;

   always_comb begin
      if ((insn & FPOP_MASK) == FPOP1_MATCH)      grp_c = GRP_ARITH;
      else if ((insn & FPOP_MASK) == FPOP2_MATCH) grp_c = GRP_CMP;
      else                                        grp_c = GRP_NONE;
   end

   assign fp_c = (grp_c != GRP_NONE);
   assign opc  = insn[OPC_LSB +: OP_W];

   fpd_opmap #(.OPC_BITS(OP_W)) opmap_i (
      .grp (grp_c),
      .opc (opc),
      .d   (dsc)
   );

   assign idx_a[0] = insn[RS1_LSB +: REG_IDX_W];
   assign idx_a[1] = insn[RS2_LSB +: REG_IDX_W];
   assign idx_a[2] = insn[RD_LSB  +: REG_IDX_W];
   assign sz_a[0]  = dsc.a_sz;
   assign sz_a[1]  = dsc.b_sz;
   assign sz_a[2]  = dsc.d_sz;

   for (genvar k = 0; k < NOPS; k++) begin : g_chk
      fpd_align_chk #(.IDX_BITS(REG_IDX_W)) chk_i (
         .idx       (idx_a[k]),
         .sz        (sz_a[k]),
         .must_zero ((k == NOPS - 1) ? dsc.cmp : 1'b0),
         .bad       (bad_a[k])
      );
   end

   always_comb begin
      res_c        = '0;
      res_c.grp    = grp_c;
      res_c.a_idx  = idx_a[0];
      res_c.b_idx  = idx_a[1];
      res_c.d_idx  = idx_a[2];
      res_c.a_sz   = dsc.a_sz;
      res_c.b_sz   = dsc.b_sz;
      res_c.d_sz   = dsc.d_sz;
      res_c.b_raw  = dsc.b_raw;
      res_c.d_raw  = dsc.d_raw;
      res_c.cmp    = dsc.cmp;
      res_c.unimpl = fp_c && !dsc.known;
      res_c.badreg = dsc.known && (|bad_a);
      res_c.trap   = res_c.badreg ? TRAP_BITS'(BADREG_TT) : '0;
   end

   fpd_out_stage #(.W(RES_W), .REG_OUT(REG_OUT)) out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .d        (res_c),
      .q_valid  (out_valid),
      .q        (res_q_bits)
   );

   assign res_q       = dec_res_t'(res_q_bits);
   assign out_group   = res_q.grp;
   assign out_rs1_idx = res_q.a_idx;
   assign out_rs2_idx = res_q.b_idx;
   assign out_rd_idx  = res_q.d_idx;
   assign out_rs1_sz  = res_q.a_sz;
   assign out_rs2_sz  = res_q.b_sz;
   assign out_rd_sz   = res_q.d_sz;
   assign out_rs2_int = res_q.b_raw;
   assign out_rd_int  = res_q.d_raw;
   assign out_cmp     = res_q.cmp;
   assign out_unimpl  = res_q.unimpl;
   assign out_badreg  = res_q.badreg;
   assign out_trap    = res_q.trap;

   if (REG_OUT) begin : g_props
      p_trap_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && out_badreg |-> out_trap == TRAP_BITS'(BADREG_TT));
      p_no_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && !out_badreg |-> out_trap == '0);
      p_unimpl_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && out_unimpl |-> !out_badreg && out_rs1_sz == 2'd0 && out_rs2_sz == 2'd0 && out_rd_sz == 2'd0);
      p_nonfp_r1: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && out_group == 2'd0 |-> !out_unimpl && !out_badreg && !out_cmp && out_rd_sz == 2'd0);
      p_quad_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && !out_badreg && out_rs2_sz == 2'd3 |-> out_rs2_idx[1:0] == 2'b00);
      p_dbl_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && !out_badreg && out_rd_sz == 2'd2 |-> !out_rd_idx[0]);
      p_cmp_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && out_cmp && !out_badreg |-> out_rd_idx == '0 && out_rd_sz == 2'd0);
   end
endmodule

// File: tb/fp_op_decoder_tb_top.sv
`timescale 1ns/1ps
module fp_op_decoder_tb_top;
   import fpd_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] insn = '0;
   logic        out_valid;
   logic [1:0]  out_group;
   logic [4:0]  out_rs1_idx, out_rs2_idx, out_rd_idx;
   logic [1:0]  out_rs1_sz, out_rs2_sz, out_rd_sz;
   logic        out_rs2_int, out_rd_int, out_cmp, out_unimpl, out_badreg;
   logic [2:0]  out_trap;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   typedef struct {
      dec_res_t exp;
      string    tag;
   } sb_item_t;
   sb_item_t sbq[$];
   dec_res_t last_exp;

   always #2.5 clk = ~clk;

   fp_op_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
      .out_valid(out_valid), .out_group(out_group),
      .out_rs1_idx(out_rs1_idx), .out_rs2_idx(out_rs2_idx), .out_rd_idx(out_rd_idx),
      .out_rs1_sz(out_rs1_sz), .out_rs2_sz(out_rs2_sz), .out_rd_sz(out_rd_sz),
      .out_rs2_int(out_rs2_int), .out_rd_int(out_rd_int), .out_cmp(out_cmp),
      .out_unimpl(out_unimpl), .out_badreg(out_badreg), .out_trap(out_trap)
   );

   function automatic dec_res_t actual();
      dec_res_t a;
      a.grp = grp_e'(out_group);
      a.a_idx = out_rs1_idx; a.b_idx = out_rs2_idx; a.d_idx = out_rd_idx;
      a.a_sz = opsz_e'(out_rs1_sz); a.b_sz = opsz_e'(out_rs2_sz); a.d_sz = opsz_e'(out_rd_sz);
      a.b_raw = out_rs2_int; a.d_raw = out_rd_int; a.cmp = out_cmp;
      a.unimpl = out_unimpl; a.badreg = out_badreg; a.trap = out_trap;
      return a;
   endfunction

   function automatic logic [31:0] mk(input bit cmpgrp, input logic [4:0] rd, input logic [8:0] op,
                                      input logic [4:0] rs1, input logic [4:0] rs2);
      return {2'b10, rd, (cmpgrp ? 6'h35 : 6'h34), rs1, op, rs2};
   endfunction

   function automatic bit misal(input opsz_e s, input logic [4:0] r);
      return (s == SZ_DBL && r[0]) || (s == SZ_QUAD && r[1:0] != 2'b00);
   endfunction

   // Expected result derived from the requirement text
   function automatic dec_res_t model(input logic [31:0] w);
      dec_res_t r;
      logic [8:0] op;
      logic [1:0] p;
      bit known;
      r = '0;
      op = w[13:5];
      p  = op[1:0];
      known = 0;
      r.a_idx = w[18:14]; r.b_idx = w[4:0]; r.d_idx = w[29:25];
      if ((w & 32'hC1F80000) == 32'h81A00000)      r.grp = GRP_ARITH;
      else if ((w & 32'hC1F80000) == 32'h81A80000) r.grp = GRP_CMP;
      if (r.grp == GRP_ARITH) begin
         if (op[8:4] == 5'h04 && p != 0) begin
            known = 1; r.a_sz = opsz_e'(p); r.b_sz = opsz_e'(p); r.d_sz = opsz_e'(p);
         end else if (op[8:2] == 7'h0A && p != 0) begin
            known = 1; r.b_sz = opsz_e'(p); r.d_sz = opsz_e'(p);
         end else if (op == 9'h069) begin
            known = 1; r.a_sz = SZ_SGL; r.b_sz = SZ_SGL; r.d_sz = SZ_DBL;
         end else if (op == 9'h06E) begin
            known = 1; r.a_sz = SZ_DBL; r.b_sz = SZ_DBL; r.d_sz = SZ_QUAD;
         end else if (op[8:4] == 5'h0C && p == 0 && op[3:2] != 0) begin
            known = 1; r.b_sz = SZ_SGL; r.b_raw = 1; r.d_sz = opsz_e'(op[3:2]);
         end else if (op[8:2] == 7'h34 && p != 0) begin
            known = 1; r.b_sz = opsz_e'(p); r.d_sz = SZ_SGL; r.d_raw = 1;
         end else if (op == 9'h001 || op == 9'h005 || op == 9'h009) begin
            known = 1; r.b_sz = SZ_SGL; r.d_sz = SZ_SGL; r.b_raw = 1; r.d_raw = 1;
         end else begin
            case (op)
               9'h0C6: begin known = 1; r.b_sz = SZ_DBL;  r.d_sz = SZ_SGL;  end
               9'h0C7: begin known = 1; r.b_sz = SZ_QUAD; r.d_sz = SZ_SGL;  end
               9'h0C9: begin known = 1; r.b_sz = SZ_SGL;  r.d_sz = SZ_DBL;  end
               9'h0CB: begin known = 1; r.b_sz = SZ_QUAD; r.d_sz = SZ_DBL;  end
               9'h0CD: begin known = 1; r.b_sz = SZ_SGL;  r.d_sz = SZ_QUAD; end
               9'h0CE: begin known = 1; r.b_sz = SZ_DBL;  r.d_sz = SZ_QUAD; end
               default: ;
            endcase
         end
      end else if (r.grp == GRP_CMP) begin
         if (op[8:4] == 5'h05 && op[3] == 1'b0 && p != 0) begin
            known = 1; r.a_sz = opsz_e'(p); r.b_sz = opsz_e'(p); r.cmp = 1;
         end
      end
      r.unimpl = (r.grp != GRP_NONE) && !known;
      if (known)
         r.badreg = misal(r.a_sz, r.a_idx) || misal(r.b_sz, r.b_idx) || misal(r.d_sz, r.d_idx)
                    || (r.cmp && r.d_idx != 0);
      r.trap = r.badreg ? 3'd6 : 3'd0;
      return r;
   endfunction

   task automatic drive(input logic [31:0] w, input string tag);
      sb_item_t it;
      @(negedge clk);
      in_valid = 1'b1;
      insn = w;
      it.exp = model(w);
      it.tag = tag;
      sbq.push_back(it);
      last_exp = it.exp;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         insn = 32'hFFFF_FFFF ^ (32'h1111_1111 * i);
      end
   endtask

   // Monitor: pops the scoreboard whenever a result is presented
   always @(negedge clk) begin
      if (rst_n && out_valid && !finished) begin
         if (sbq.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL R9: out_valid with no pending item (actual 1, expected 0)");
         end else begin
            sb_item_t it;
            dec_res_t a;
            it = sbq.pop_front();
            a = actual();
            n_tests++;
            if (a !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, a, it.exp);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_tests++;
      if (out_valid !== 1'b0 || actual() !== dec_res_t'('0)) begin
         n_fail++;
         $display("FAIL R9 reset: actual %b/%h expected 0/0", out_valid, actual());
      end
      rst_n = 1'b1;
      idle(2);

      // R1: not an FP operate
      drive(32'h0000_0000, "R1 zero word");
      drive(32'h1234_5678, "R1 arbitrary word");
      drive(mk(1'b0, 5'd1, 9'h041, 5'd2, 5'd3) ^ 32'h0008_0000, "R1 mask miss bit19");
      drive(mk(1'b0, 5'd1, 9'h041, 5'd2, 5'd3) ^ 32'h4000_0000, "R1 mask miss bit30");
      // R2/R3 arithmetic
      drive(mk(1'b0, 5'd31, 9'h041, 5'd7, 5'd9), "R2 R3 add single odd regs");
      drive(mk(1'b0, 5'd4, 9'h04E, 5'd2, 5'd6), "R3 divide double aligned");
      drive(mk(1'b0, 5'd4, 9'h046, 5'd3, 5'd6), "R5 sub double odd rs1");
      drive(mk(1'b0, 5'd8, 9'h04B, 5'd4, 5'd2), "R5 mul quad rs2=2");
      drive(mk(1'b0, 5'd8, 9'h043, 5'd4, 5'd12), "R3 add quad aligned");
      drive(mk(1'b0, 5'd4, 9'h02B, 5'd3, 5'd8), "R5 sqrt quad unused rs1 odd");
      drive(mk(1'b0, 5'd5, 9'h029, 5'd0, 5'd7), "R3 sqrt single");
      drive(mk(1'b0, 5'd2, 9'h069, 5'd1, 5'd3), "R3 single x single to double");
      drive(mk(1'b0, 5'd6, 9'h06E, 5'd2, 5'd4), "R5 double x double quad rd=6");
      // R4 conversions
      drive(mk(1'b0, 5'd4, 9'h0CC, 5'd0, 5'd5), "R4 int to quad");
      drive(mk(1'b0, 5'd7, 9'h0D3, 5'd0, 5'd8), "R4 quad to int");
      drive(mk(1'b0, 5'd3, 9'h0D2, 5'd0, 5'd1), "R5 double to int odd rs2");
      drive(mk(1'b0, 5'd9, 9'h0C6, 5'd0, 5'd2), "R4 double to single");
      drive(mk(1'b0, 5'd10, 9'h0CB, 5'd0, 5'd12), "R4 quad to double");
      drive(mk(1'b0, 5'd13, 9'h001, 5'd0, 5'd11), "R4 move raw");
      drive(mk(1'b0, 5'd13, 9'h009, 5'd0, 5'd11), "R4 absolute raw");
      // R6 compares
      drive(mk(1'b1, 5'd0, 9'h052, 5'd2, 5'd4), "R6 compare double rd0");
      drive(mk(1'b1, 5'd1, 9'h057, 5'd4, 5'd8), "R6 R7 signalling quad rd1");
      drive(mk(1'b1, 5'd0, 9'h055, 5'd3, 5'd5), "R6 compare single odd");
      drive(mk(1'b1, 5'd0, 9'h053, 5'd4, 5'd10), "R6 R5 compare quad rs2=10");
      // R8 unimplemented
      drive(mk(1'b0, 5'd3, 9'h000, 5'd1, 5'd1), "R8 group1 code 0");
      drive(mk(1'b0, 5'd3, 9'h044, 5'd1, 5'd1), "R8 group1 code 0x044");
      drive(mk(1'b1, 5'd3, 9'h041, 5'd1, 5'd1), "R8 group2 add code");
      drive(mk(1'b0, 5'd0, 9'h051, 5'd0, 5'd0), "R8 compare code in group1");
      // R7 trap after fault then clean word back to back
      drive(mk(1'b0, 5'd1, 9'h042, 5'd0, 5'd0), "R7 double rd odd");
      drive(mk(1'b0, 5'd0, 9'h042, 5'd0, 5'd0), "R7 clean after fault");
      idle(1);
      // R9: hold while idle
      idle(3);
      n_tests++;
      if (out_valid !== 1'b0 || actual() !== last_exp) begin
         n_fail++;
         $display("FAIL R9 hold: actual %b/%h expected 0/%h", out_valid, actual(), last_exp);
      end
      // R9: gapped captures
      drive(mk(1'b0, 5'd2, 9'h0C9, 5'd0, 5'd3), "R9 gap item a");
      idle(2);
      drive(mk(1'b1, 5'd0, 9'h056, 5'd6, 5'd2), "R9 gap item b");
      idle(3);
      n_tests++;
      if (sbq.size() != 0) begin
         n_fail++;
         $display("FAIL R9 drain: actual %0d pending expected 0", sbq.size());
      end
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule